// File: doc/BRIEF.md
# Programmable-Function Two-Bit Adder Cell Chain

This block is a cascade of configurable arithmetic cells. Each cell holds four 4-input lookup tables arranged as two pairs. Each pair feeds one full-adder bit, so every sum bit adds the results of two programmable functions rather than two raw operands. The two adder bits of a cell ripple into each other. The cell's carry output feeds the next cell, so a chain of cells forms a wide adder, subtractor, comparator or counter.

Every sum bit is available in two forms: as a combinational output and as a register. The register has a clock enable, a synchronous clear and a synchronous load. Clear and load are shared across the whole chain, and a per-bit parameter decides whether each register obeys them. The LUT outputs are also brought out directly, so the carry chain can be used while the LUTs serve as plain logic.

The lookup masks are parameters. The default masks turn the chain into an adder/subtractor. In the feedback variant, each register drives its own LUT pair, which gives an up/down counter with an enable.

Top module: `lutadd_chain`

## Requirements
- R1: Each LUT output equals bit {d,c,b,a} of its 16-bit mask, with index bit 0 = shared input a (`dat_a`), bit 1 = shared input b (`dat_b`), bit 2 = the pair's c input and bit 3 = the pair's d input (`opy`). With the default masks, `fx[i]` = c and `fy[i]` = b & (d ^ a).
- R2: Each `sum[i]` is the XOR of `fx[i]`, `fy[i]` and the carry into that bit, so {`cout`,`sum`} = `fx` + `fy` + `cin`.
- R3: The carry enters bit 0 of cell 0 through `cin` and ripples through the two bits of each cell in turn. It then passes to the next cell, and the last cell's carry appears on `cout`.
- R4: `sum` and `cout` are combinational: they follow the inputs within the same cycle, with no clock edge.
- R5: On a rising clock edge with `ce`=1, `sclr`=0 and `sload`=0, `q` takes the value of `sum`.
- R6: With `ce`=0, `q` keeps its value whatever `sclr`, `sload` or the operands do.
- R7: With `ce`=1, `sclr` clears every register whose clear-use bit is set, even when `sload` is also high.
- R8: With `ce`=1, `sclr`=0 and `sload`=1, each register whose load-use bit is set takes its `load_val` bit, and each other register captures its `sum` bit.
- R9: An active-low `rst_n` sets all of `q` to zero at once.
- R10: With `dat_b`=0 under the default masks, `fy` is zero, `fx` still shows the c inputs as plain logic, and the carry chain still yields `cout` of `opx`+`cin`.
- R11: With the default masks, `dat_a`=1, `dat_b`=1 and `cin`=1, `sum` = `opx` − `opy` modulo 2^W, and `cout`=1 exactly when `opx` ≥ `opy`.
- R12: In the feedback variant, each register output drives its own c input, and `opy`=0. With `dat_b`=1, `dat_a`=0 and `cin`=1, `q` counts up by one per enabled clock. With `dat_b`=1, `dat_a`=1 and `cin`=0, it counts down by one. With `dat_b`=0 and `cin`=0, it holds. In both directions it wraps at the ends of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| dat_a | input | 1 | Shared LUT input a (index bit 0) |
| dat_b | input | 1 | Shared LUT input b (index bit 1) |
| cin | input | 1 | Carry into bit 0 |
| opx | input | W | Per-pair c inputs (unused in the feedback variant) |
| opy | input | W | Per-pair d inputs |
| ce | input | 1 | Register clock enable |
| sclr | input | 1 | Chain-wide synchronous clear |
| sload | input | 1 | Chain-wide synchronous load |
| load_val | input | W | Synchronous load data |
| sum | output | W | Combinational sum bits |
| q | output | W | Registered sum bits |
| cout | output | 1 | Carry out of the last cell |
| fx | output | W | First LUT output of each pair |
| fy | output | W | Second LUT output of each pair |

## Verification
The adder is driven with operand patterns that isolate each part of its function:
- All-zero and all-one operands, with both carry-in values, show whether the carry enters at bit 0 and ripples through every cell to `cout`.
- The sign-bit pair 0x8000 + 0x8000 checks for overflow wrap.
- Subtract patterns (a smaller value minus a larger one, and equal values) tell the inverting LUT mask apart from a pass-through mask, and check that the borrow appears on `cout`.
- Random operands catch wrong bit ordering between cells.

On the register side, clear and load are raised together, and one bit has load disabled, to show the priority order and the per-bit use masks. The feedback counter is stepped across the 0xFFFF/0x0000 boundary in both directions.

// File: rtl/lac_pkg.sv
package lac_pkg;

   // register control bundle shared by every bit
   typedef struct packed {
      logic ce;
      logic sclr;
      logic sload;
   } lac_ctl_t;

   // pick one mask bit; a is the least significant index bit
   function automatic logic lut_pick(input logic [15:0] m,
                                     input logic a, input logic b,
                                     input logic c, input logic d);
      return m[{d, c, b, a}];
   endfunction

endpackage

// File: rtl/lac_lut4.sv
module lac_lut4 #(
   parameter logic [15:0] MASK = 16'h0000
) (
   input  logic a,
   input  logic b,
   input  logic c,
   input  logic d,
   output logic y
);
   always_comb y = lac_pkg::lut_pick(MASK, a, b, c, d);
endmodule

// File: rtl/lac_fa.sv
module lac_fa (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p;
   always_comb begin
      p  = x ^ y;
      s  = p ^ ci;
      co = (x & y) | (ci & p);
   end
endmodule

// File: rtl/lac_reg.sv
module lac_reg #(
   parameter bit USE_CLR = 1'b1,
   parameter bit USE_LD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lac_pkg::lac_ctl_t ctl,
   input  logic             d,
   input  logic             ld,
   output logic             q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (ctl.ce) begin
         if (USE_CLR && ctl.sclr)
            q <= 1'b0;
         else if (USE_LD && ctl.sload)
            q <= ld;
         else
            q <= d;
      end
   end
endmodule

// File: rtl/lac_cell.sv
module lac_cell #(
   parameter logic [15:0] MASK_X   = 16'hF0F0,
   parameter logic [15:0] MASK_Y   = 16'h4488,
   parameter bit          FEEDBACK = 1'b0,
   parameter logic [1:0]  CLR_USE  = 2'b11,
   parameter logic [1:0]  LD_USE   = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sh_a,
   input  logic              sh_b,
   input  logic              cin,
   input  logic [1:0]        px,
   input  logic [1:0]        py,
   input  lac_pkg::lac_ctl_t ctl,
   input  logic [1:0]        ldv,
   output logic [1:0]        sum,
   output logic [1:0]        q,
   output logic              cout,
   output logic [1:0]        fx,
   output logic [1:0]        fy
);
   localparam int NBIT = 2;

   logic [NBIT:0] cy;
   assign cy[0] = cin;
   assign cout  = cy[NBIT];

   for (genvar k = 0; k < NBIT; k++) begin : g_bit
      logic dc;
      if (FEEDBACK) begin : g_fb
         assign dc = q[k];
      end else begin : g_ext
         assign dc = px[k];
      end

      lac_lut4 #(.MASK(MASK_X)) u_lx (
         .a(sh_a), .b(sh_b), .c(dc), .d(py[k]), .y(fx[k]));
      lac_lut4 #(.MASK(MASK_Y)) u_ly (
         .a(sh_a), .b(sh_b), .c(dc), .d(py[k]), .y(fy[k]));

      lac_fa u_fa (
         .x(fx[k]), .y(fy[k]), .ci(cy[k]), .s(sum[k]), .co(cy[k+1]));

      lac_reg #(.USE_CLR(CLR_USE[k]), .USE_LD(LD_USE[k])) u_rg (
         .clk(clk), .rst_n(rst_n), .ctl(ctl),
         .d(sum[k]), .ld(ldv[k]), .q(q[k]));
   end
endmodule

// File: rtl/lutadd_chain.sv
module lutadd_chain #(
   parameter int                  NCELL    = 8,
   parameter logic [15:0]         MASK_X   = 16'hF0F0,
   parameter logic [15:0]         MASK_Y   = 16'h4488,
   parameter bit                  FEEDBACK = 1'b0,
   parameter logic [2*NCELL-1:0]  CLR_USE  = '1,
   parameter logic [2*NCELL-1:0]  LD_USE   = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dat_a,
   input  logic                 dat_b,
   input  logic                 cin,
   input  logic [2*NCELL-1:0]   opx,
   input  logic [2*NCELL-1:0]   opy,
   input  logic                 ce,
   input  logic                 sclr,
   input  logic                 sload,
   input  logic [2*NCELL-1:0]   load_val,
   output logic [2*NCELL-1:0]   sum,
   output logic [2*NCELL-1:0]   q,
   output logic                 cout,
   output logic [2*NCELL-1:0]   fx,
   output logic [2*NCELL-1:0]   fy
);
   localparam int W = 2 * NCELL;

   if (NCELL < 1) begin : g_bad_ncell
      $error("lutadd_chain: NCELL must be at least 1");
   end

   lac_pkg::lac_ctl_t ctl;
   assign ctl = '{ce: ce, sclr: sclr, sload: sload};

   logic [NCELL:0] cc;
   assign cc[0] = cin;
   assign cout  = cc[NCELL];

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      lac_cell #(
         .MASK_X  (MASK_X),
         .MASK_Y  (MASK_Y),
         .FEEDBACK(FEEDBACK),
         .CLR_USE (CLR_USE[2*i +: 2]),
         .LD_USE  (LD_USE[2*i +: 2])
      ) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .sh_a (dat_a),
         .sh_b (dat_b),
         .cin  (cc[i]),
         .px   (opx[2*i +: 2]),
         .py   (opy[2*i +: 2]),
         .ctl  (ctl),
         .ldv  (load_val[2*i +: 2]),
         .sum  (sum[2*i +: 2]),
         .q    (q[2*i +: 2]),
         .cout (cc[i+1]),
         .fx   (fx[2*i +: 2]),
         .fy   (fy[2*i +: 2])
      );
   end
endmodule

// File: rtl/lutadd_chk.sv
module lutadd_chk #(
   parameter int          W       = 16,
   parameter logic [W-1:0] CLR_USE = '1,
   parameter logic [W-1:0] LD_USE  = '1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cin,
   input logic         ce,
   input logic         sclr,
   input logic         sload,
   input logic [W-1:0] load_val,
   input logic [W-1:0] sum,
   input logic [W-1:0] q,
   input logic         cout,
   input logic [W-1:0] fx,
   input logic [W-1:0] fy
);
   // R2
   sum_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {cout, sum} == ({1'b0, fx} + {1'b0, fy} + {{W{1'b0}}, cin}));

   // R5
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !sclr && !sload) |=> (q == $past(sum)));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(q));

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && sclr) |=> ((q & CLR_USE) == '0));

   // R8
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !sclr && sload) |=> ((q & LD_USE) == ($past(load_val) & LD_USE)));
endmodule

bind lutadd_chain lutadd_chk #(.W(W), .CLR_USE(CLR_USE), .LD_USE(LD_USE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cin(cin), .ce(ce), .sclr(sclr), .sload(sload),
   .load_val(load_val), .sum(sum), .q(q), .cout(cout), .fx(fx), .fy(fy));

// File: tb/sim_lutadd_chain.sv
module sim_lutadd_chain;
   localparam int W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic rst_n;
   // adder instance signals
   logic         a_sub, b_en, cin, ce, sclr, sload;
   logic [W-1:0] x, y, ldv, sum, q, fx, fy;
   logic         cout;
   // counter instance signals
   logic         c_down, c_en, c_cin, c_ce, c_sclr, c_sload;
   logic [W-1:0] c_ldv, c_sum, c_q, c_fx, c_fy;
   logic         c_cout;

   int n_cmp = 0;
   int n_bad = 0;

   lutadd_chain #(.NCELL(8), .LD_USE(16'h7FFF)) u0 (
      .clk(clk), .rst_n(rst_n), .dat_a(a_sub), .dat_b(b_en), .cin(cin),
      .opx(x), .opy(y), .ce(ce), .sclr(sclr), .sload(sload), .load_val(ldv),
      .sum(sum), .q(q), .cout(cout), .fx(fx), .fy(fy));

   lutadd_chain #(.NCELL(8), .FEEDBACK(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .dat_a(c_down), .dat_b(c_en), .cin(c_cin),
      .opx('0), .opy('0), .ce(c_ce), .sclr(c_sclr), .sload(c_sload),
      .load_val(c_ldv), .sum(c_sum), .q(c_q), .cout(c_cout), .fx(c_fx), .fy(c_fy));

   // {sub, cin, x, y}
   localparam logic [33:0] VEC [8] = '{
      {1'b0, 1'b0, 16'h0000, 16'h0000},
      {1'b0, 1'b1, 16'hFFFF, 16'h0000},
      {1'b0, 1'b0, 16'hFFFF, 16'h0000},
      {1'b0, 1'b0, 16'h8000, 16'h8000},
      {1'b1, 1'b1, 16'h0005, 16'h0007},
      {1'b1, 1'b1, 16'h1234, 16'h1234},
      {1'b0, 1'b1, 16'h7FFF, 16'h7FFF},
      {1'b1, 1'b1, 16'h0000, 16'h0001}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // apply operands, check combinational outputs, clock, check register
   task automatic run_add(input logic s, input logic ci,
                          input logic [W-1:0] xa, input logic [W-1:0] ya);
      logic [W-1:0] yy;
      logic [W:0]   e;
      @(negedge clk);
      a_sub = s; b_en = 1'b1; cin = ci; x = xa; y = ya;
      ce = 1'b1; sclr = 1'b0; sload = 1'b0;
      #1;
      yy = s ? ~ya : ya;
      e  = {1'b0, xa} + {1'b0, yy} + {{W{1'b0}}, ci};
      chk("R1 fx", {16'h0, fx}, {16'h0, xa});
      chk("R1 fy", {16'h0, fy}, {16'h0, yy});
      chk(s ? "R11 sum" : "R2 R4 sum", {16'h0, sum}, {16'h0, e[W-1:0]});
      chk("R3 cout", {31'h0, cout}, {31'h0, e[W]});
      step();
      chk("R5 q", {16'h0, q}, {16'h0, e[W-1:0]});
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      a_sub = 0; b_en = 1; cin = 1; x = 16'h00FF; y = 16'h0F0F;
      ce = 1; sclr = 0; sload = 0; ldv = 16'hAAAA;
      c_down = 0; c_en = 1; c_cin = 1; c_ce = 1; c_sclr = 0; c_sload = 0; c_ldv = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset q", {16'h0, q}, 32'h0);
      chk("R9 reset counter", {16'h0, c_q}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < 8; i++)
         run_add(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

      // random operands, both carry-in values
      for (int i = 0; i < 40; i++)
         run_add(1'(i % 3 == 0), 1'(i % 2), 16'($urandom), 16'($urandom));

      // R6: ce low holds, even with clear and load requested
      run_add(1'b0, 1'b0, 16'h1111, 16'h2222);       // q = 3333
      @(negedge clk);
      ce = 0; x = 16'hABCD; sclr = 1; sload = 1;
      step();
      chk("R6 hold", {16'h0, q}, 32'h3333);

      // R7: clear beats load
      @(negedge clk);
      ce = 1; sclr = 1; sload = 1; ldv = 16'hFFFF;
      step();
      chk("R7 clear", {16'h0, q}, 32'h0);

      // R8: load on bits 14..0, bit 15 has load disabled and takes sum
      @(negedge clk);
      sclr = 0; sload = 1; ldv = 16'h1234;
      a_sub = 0; b_en = 1; cin = 0; x = 16'h8000; y = 16'h0000;
      step();
      chk("R8 load mask", {16'h0, q}, 32'h9234);

      // R10: LUTs as plain logic, carry still works
      @(negedge clk);
      sload = 0; ce = 0; b_en = 0; a_sub = 1; x = 16'hFFFF; y = 16'h5A5A; cin = 1;
      #1;
      chk("R10 fy zero", {16'h0, fy}, 32'h0);
      chk("R10 fx logic", {16'h0, fx}, 32'hFFFF);
      chk("R10 cout", {31'h0, cout}, 32'h1);
      chk("R10 sum", {16'h0, sum}, 32'h0);

      // R12: counter preset, wrap up, wrap down, hold
      @(negedge clk);
      c_sload = 1; c_ldv = 16'hFFFE;
      step();
      chk("R12 preset", {16'h0, c_q}, 32'hFFFE);
      @(negedge clk);
      c_sload = 0; c_en = 1; c_down = 0; c_cin = 1;
      step();
      chk("R12 up", {16'h0, c_q}, 32'hFFFF);
      step();
      chk("R12 up wrap", {16'h0, c_q}, 32'h0000);
      step();
      chk("R12 up", {16'h0, c_q}, 32'h0001);
      @(negedge clk);
      c_down = 1; c_cin = 0;
      step();
      chk("R12 down", {16'h0, c_q}, 32'h0000);
      step();
      chk("R12 down wrap", {16'h0, c_q}, 32'hFFFF);
      @(negedge clk);
      c_en = 0; c_cin = 0;
      step();
      step();
      chk("R12 disabled hold", {16'h0, c_q}, 32'hFFFF);

      summary();
   end
endmodule